// File: doc/BRIEF.md
# Synchronous Memory Sleep Sequencer

This block moves a synchronous memory into and out of a low-power sleep state. The sleep request comes from outside the clock domain. It is passed through a flop synchronizer. A four-state sequencer then applies a fixed number of clock cycles to enter sleep and a fixed number to recover from it. The sequencer drives a power-down enable to the storage core. Stored contents are kept intact throughout; this block only decides when the core may drop to its retention level.

Chip enables and the two address strobes (processor-side and controller-side) pass through the block to the memory. They are forwarded only while the memory is fully awake. During entry, sleep and recovery they are forced inactive. Any attempt to use them in those states raises a registered protocol-error pulse, and the attempted access is discarded. The same flag is raised when a sleep request is taken while the device is still selected. Any access in flight at that moment is not guaranteed to complete.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: After reset, the block is awake. State code is 0, `power_down` is 0, `access_open` is 1 and `proto_err` is 0.
- R2: The request passes through SYNC_STAGES flops. The state leaves code 0 on the rising edge that follows the one where the last synchronizer flop captures the new level. A request held low keeps the block awake.
- R3: The entering state (code 1) lasts exactly ENTRY_CYCLES cycles and is then followed by the sleep state (code 2).
- R4: `power_down` is 1 exactly while the state code is 1 or 2.
- R5: In the sleep state, a synchronized low request starts the recovery state (code 3). Recovery lasts exactly EXIT_CYCLES cycles and then returns to code 0.
- R6: `chip_en_o`, `stb_proc_o` and `stb_ctrl_o` follow their inputs while the state code is 0. They are 0 in every other state, and `access_open` is 1 only in state code 0.
- R7: If any chip enable or strobe input is 1 while the state code is not 0, `proto_err` is 1 in the following cycle. The attempted access does not reach the outputs.
- R8: If the synchronized request is seen in state code 0 while any chip enable is 1, `proto_err` is 1 in the following cycle.
- R9: If the request drops during entry, entry still completes. The sleep state then lasts one cycle, and recovery follows.
- R10: If the request rises again during recovery, recovery still completes. The block spends one cycle in code 0 and then starts entry again.
- R11: The state code on `state_o` is 0 awake, 1 entering, 2 asleep, 3 recovering. Code 0 is never followed directly by code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep request, asynchronous to clk |
| chip_en | input | NUM_CE | Chip enables, active high |
| stb_proc | input | 1 | Processor-side address strobe, active high |
| stb_ctrl | input | 1 | Controller-side address strobe, active high |
| chip_en_o | output | NUM_CE | Gated chip enables to the memory |
| stb_proc_o | output | 1 | Gated processor-side strobe |
| stb_ctrl_o | output | 1 | Gated controller-side strobe |
| power_down | output | 1 | Power-down enable to the core |
| access_open | output | 1 | High when accesses are accepted |
| proto_err | output | 1 | One-cycle protocol-error pulse |
| state_o | output | 2 | Sequencer state code |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, two-cycle entry, two-cycle recovery and three chip enables. With such short windows, random toggling of the request lands inside entry and recovery often enough to exercise R9 and R10. Random enables and strobes hit every state, so gating and both error causes are covered. A reference model in the bench, built from the requirements, predicts every output on every cycle. Directed phases cover the reset state, a clean sleep round trip and both mid-sequence reversals.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

   typedef enum logic [1:0] {
      ST_AWAKE   = 2'd0,
      ST_ENTER   = 2'd1,
      ST_ASLEEP  = 2'd2,
      ST_RECOVER = 2'd3
   } slp_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sleep_seq_sync.sv
module sleep_seq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sleep_seq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
   import sleep_seq_pkg::*;
#(
   parameter int unsigned ENTRY_CYCLES = 2,
   parameter int unsigned EXIT_CYCLES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   output slp_state_e state_q,
   output logic       power_down_q
);

   localparam int unsigned MAXC = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
   localparam int unsigned CW   = cnt_width(MAXC);
   localparam logic [CW-1:0] ENT_LD = CW'(ENTRY_CYCLES - 1);
   localparam logic [CW-1:0] EXT_LD = CW'(EXIT_CYCLES - 1);

   if (ENTRY_CYCLES < 1 || EXIT_CYCLES < 1) begin : g_bad_cycles
      $error("sleep_seq_fsm: entry and exit cycle counts must be at least 1");
   end

   slp_state_e    nxt_state;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      nxt_state = state_q;
      cnt_d     = cnt_q;
      unique case (state_q)
         ST_AWAKE: begin
            if (req_s) begin
               nxt_state = ST_ENTER;
               cnt_d     = ENT_LD;
            end
         end
         ST_ENTER: begin
            if (cnt_q == '0) nxt_state = ST_ASLEEP;
            else             cnt_d     = cnt_q - 1'b1;
         end
         ST_ASLEEP: begin
            if (!req_s) begin
               nxt_state = ST_RECOVER;
               cnt_d     = EXT_LD;
            end
         end
         ST_RECOVER: begin
            if (cnt_q == '0) nxt_state = ST_AWAKE;
            else             cnt_d     = cnt_q - 1'b1;
         end
         default: nxt_state = ST_AWAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_AWAKE;
         cnt_q        <= '0;
         power_down_q <= 1'b0;
      end else begin
         state_q      <= nxt_state;
         cnt_q        <= cnt_d;
         power_down_q <= (nxt_state == ST_ENTER) || (nxt_state == ST_ASLEEP);
      end
   end

endmodule

// File: rtl/sleep_seq_guard.sv
module sleep_seq_guard
   import sleep_seq_pkg::*;
#(
   parameter int unsigned NUM_CE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  slp_state_e        state_q,
   input  logic              req_s,
   input  logic [NUM_CE-1:0] ce_in,
   input  logic              stb_p_in,
   input  logic              stb_c_in,
   output logic [NUM_CE-1:0] ce_out,
   output logic              stb_p_out,
   output logic              stb_c_out,
   output logic              open_o,
   output logic              err_q
);

   if (NUM_CE < 1) begin : g_bad_ce
      $error("sleep_seq_guard: NUM_CE must be at least 1");
   end

   logic open_w;
   logic any_ce;
   logic closed_hit;
   logic sel_hit;

   assign open_w = (state_q == ST_AWAKE);
   assign any_ce = |ce_in;

   for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
      assign ce_out[i] = ce_in[i] & open_w;
   end

   assign stb_p_out  = stb_p_in & open_w;
   assign stb_c_out  = stb_c_in & open_w;
   assign open_o     = open_w;

   assign closed_hit = !open_w && (any_ce || stb_p_in || stb_c_in);
   assign sel_hit    = open_w && req_s && any_ce;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= closed_hit || sel_hit;
   end

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
   import sleep_seq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned ENTRY_CYCLES = 2,
   parameter int unsigned EXIT_CYCLES  = 2,
   parameter int unsigned NUM_CE       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic [NUM_CE-1:0] chip_en,
   input  logic              stb_proc,
   input  logic              stb_ctrl,
   output logic [NUM_CE-1:0] chip_en_o,
   output logic              stb_proc_o,
   output logic              stb_ctrl_o,
   output logic              power_down,
   output logic              access_open,
   output logic              proto_err,
   output logic [1:0]        state_o
);

   logic       req_sync;
   slp_state_e state_q;

   sleep_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (sleep_req),
      .q_sync  (req_sync)
   );

   sleep_seq_fsm #(
      .ENTRY_CYCLES (ENTRY_CYCLES),
      .EXIT_CYCLES  (EXIT_CYCLES)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_s        (req_sync),
      .state_q      (state_q),
      .power_down_q (power_down)
   );

   sleep_seq_guard #(.NUM_CE(NUM_CE)) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .state_q   (state_q),
      .req_s     (req_sync),
      .ce_in     (chip_en),
      .stb_p_in  (stb_proc),
      .stb_c_in  (stb_ctrl),
      .ce_out    (chip_en_o),
      .stb_p_out (stb_proc_o),
      .stb_c_out (stb_ctrl_o),
      .open_o    (access_open),
      .err_q     (proto_err)
   );

   assign state_o = state_q;

endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
   parameter int unsigned NUM_CE = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_s,
   input logic [1:0]        state,
   input logic              power_down,
   input logic              access_open,
   input logic [NUM_CE-1:0] chip_en,
   input logic              stb_proc,
   input logic              stb_ctrl,
   input logic [NUM_CE-1:0] chip_en_o,
   input logic              stb_proc_o,
   input logic              stb_ctrl_o,
   input logic              proto_err
);

   a_r2_hold_awake: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 && !req_s) |=> (state == 2'd0));

   a_r3_enter_path: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1) |=> (state == 2'd1 || state == 2'd2));

   a_r5_recover_path: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd3) |=> (state == 2'd3 || state == 2'd0));

   a_r4_pwr_state: assert property (@(posedge clk) disable iff (!rst_n)
      power_down |-> (state == 2'd1 || state == 2'd2));

   a_r6_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 2'd0) |-> (!access_open && chip_en_o == '0 && !stb_proc_o && !stb_ctrl_o));

   a_r7_closed_access: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 2'd0 && (|chip_en || stb_proc || stb_ctrl)) |=> proto_err);

   a_r8_selected_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 && req_s && |chip_en) |=> proto_err);

   a_r11_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0) |=> (state != 2'd2));

endmodule

bind sleep_seq_ctrl sleep_seq_chk #(.NUM_CE(NUM_CE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_s       (req_sync),
   .state       (state_o),
   .power_down  (power_down),
   .access_open (access_open),
   .chip_en     (chip_en),
   .stb_proc    (stb_proc),
   .stb_ctrl    (stb_ctrl),
   .chip_en_o   (chip_en_o),
   .stb_proc_o  (stb_proc_o),
   .stb_ctrl_o  (stb_ctrl_o),
   .proto_err   (proto_err)
);

// File: tb/sim_sleep_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_seq_ctrl;

   localparam int SYNC = 2;
   localparam int ENT  = 2;
   localparam int EXT  = 2;
   localparam int NCE  = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sleep_req = 1'b0;
   logic [NCE-1:0] chip_en = '0;
   logic           stb_proc = 1'b0;
   logic           stb_ctrl = 1'b0;
   logic [NCE-1:0] chip_en_o;
   logic           stb_proc_o, stb_ctrl_o, power_down, access_open, proto_err;
   logic [1:0]     state_o;

   always #5 clk = ~clk;

   sleep_seq_ctrl #(
      .SYNC_STAGES(SYNC), .ENTRY_CYCLES(ENT), .EXIT_CYCLES(EXT), .NUM_CE(NCE)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_en(chip_en),
      .stb_proc(stb_proc), .stb_ctrl(stb_ctrl), .chip_en_o(chip_en_o),
      .stb_proc_o(stb_proc_o), .stb_ctrl_o(stb_ctrl_o), .power_down(power_down),
      .access_open(access_open), .proto_err(proto_err), .state_o(state_o)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   bit    chk_on   = 1'b0;
   string cur_req  = "R11";

   // reference model, built from the requirements
   logic [SYNC-1:0] m_sync;
   logic [1:0]      m_st;
   int              m_cnt;
   logic            m_err;
   string           m_err_tag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sync = '0; m_st = 2'd0; m_cnt = 0; m_err = 1'b0; m_err_tag = "R7";
      end else begin
         logic rs;
         rs = m_sync[SYNC-1];
         m_err = 1'b0;
         if (m_st != 2'd0 && (|chip_en || stb_proc || stb_ctrl)) begin
            m_err = 1'b1; m_err_tag = "R7";
         end
         if (m_st == 2'd0 && rs && |chip_en) begin
            m_err = 1'b1; m_err_tag = "R8";
         end
         case (m_st)
            2'd0: if (rs) begin m_st = 2'd1; m_cnt = ENT; end
            2'd1: begin m_cnt--; if (m_cnt == 0) m_st = 2'd2; end
            2'd2: if (!rs) begin m_st = 2'd3; m_cnt = EXT; end
            default: begin m_cnt--; if (m_cnt == 0) m_st = 2'd0; end
         endcase
         m_sync = {m_sync[SYNC-2:0], sleep_req};
      end
   end

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         logic open;
         open = (m_st == 2'd0);
         chk((m_st == 2'd1) ? "R3" : (m_st == 2'd3) ? "R5" : cur_req, "state", state_o, m_st);
         chk("R4", "power_down", power_down, (m_st == 2'd1 || m_st == 2'd2));
         chk("R6", "access_open", access_open, open);
         chk("R6", "chip_en_o", chip_en_o, open ? chip_en : '0);
         chk("R6", "strobes", {stb_proc_o, stb_ctrl_o}, open ? {stb_proc, stb_ctrl} : 2'b00);
         chk(m_err_tag, "proto_err", proto_err, m_err);
      end
   end

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

   initial begin
      void'($urandom(32'd4711));
      step(3);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1", "state after reset", state_o, 0);
      chk("R1", "power_down after reset", power_down, 0);
      chk("R1", "access_open after reset", access_open, 1);
      chk("R1", "proto_err after reset", proto_err, 0);
      step(1);
      chk_on = 1'b1;

      // R2: synchronizer latency, then a clean round trip
      cur_req = "R2";
      sleep_req = 1'b1;
      step(SYNC);
      chk("R2", "still awake during sync", state_o, 0);
      step(1);
      chk("R2", "entry after sync", state_o, 1);
      step(ENT);
      chk("R3", "asleep after entry", state_o, 2);
      stb_proc = 1'b1; chip_en = 3'b010;       // R7: access while asleep
      step(1);
      stb_proc = 1'b0; chip_en = '0;
      chk("R7", "error after closed access", proto_err, 1);
      sleep_req = 1'b0;
      step(SYNC + 1);
      chk("R5", "recovering", state_o, 3);
      step(EXT);
      chk("R5", "awake again", state_o, 0);
      step(3);

      // R8: request while selected
      cur_req = "R8";
      chip_en = 3'b001;
      sleep_req = 1'b1;
      step(SYNC + 1);
      chk("R8", "selected entry flagged", proto_err, 1);
      chip_en = '0;
      step(ENT + 2);

      // R9: drop during entry
      cur_req = "R9";
      sleep_req = 1'b0;
      step(6);
      sleep_req = 1'b1;
      step(SYNC + 1);
      chk("R9", "entering", state_o, 1);
      sleep_req = 1'b0;
      step(ENT);
      chk("R9", "entry completes", state_o, 2);
      step(1);
      chk("R9", "single sleep cycle then recover", state_o, 3);
      step(EXT + 2);

      // R10: rise during recovery
      cur_req = "R10";
      sleep_req = 1'b1;
      step(SYNC + 1 + ENT + 1);
      sleep_req = 1'b0;
      step(SYNC + 1);
      chk("R10", "recovering", state_o, 3);
      sleep_req = 1'b1;
      step(EXT);
      chk("R10", "recovery completes", state_o, 0);
      step(SYNC);
      chk("R10", "re-entry", state_o, 1);
      step(10);

      // random phase, checked by the model every cycle (R11)
      cur_req = "R11";
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 9) == 0) sleep_req = ~sleep_req;
         chip_en  = ($urandom_range(0, 3) == 0) ? NCE'($urandom) : '0;
         stb_proc = ($urandom_range(0, 5) == 0);
         stb_ctrl = ($urandom_range(0, 5) == 0);
         step(1);
      end
      chk_on = 1'b0;
      done = 1'b1;
      summary();
   end

endmodule